// File: doc/BRIEF.md
# Signed Binary to Residue Converter

This block takes a 16-bit two's complement integer and produces its residue with respect to one fixed modulus. The modulus defaults to 29, which gives a 5-bit result. Each instance handles a single modulus. A residue number system front end places one instance per channel, and each instance sees the same input word.

The block first forms the magnitude of the input. For a negative word this is the bitwise inverse plus one, held as an unsigned 16-bit value, so -32768 becomes 32768. The magnitude is cut into 5-bit segments, and the top segment holds whatever bits remain. Each segment drives its own 32-entry constant table. An entry holds the residue of the segment value shifted to its bit position, and the tables are filled at elaboration from the modulus parameter. A tree of two-operand modular adders combines the table outputs, and no divider appears anywhere. When the input was negative, a last stage replaces a nonzero sum s with m − s.

There are three register stages: table read, adder tree and sign correction. An output valid flag follows the input valid flag through the same three stages. The block accepts a new word every cycle and has no back-pressure.

Top module: `tcs_rns_conv`

## Requirements
- R1: For a non-negative input x, `res_o` equals x mod m, with m = 29 by default.
- R2: For a negative input x with |x| mod m nonzero, `res_o` equals m − (|x| mod m). Here |x| is the bitwise inverse of x plus one, read as unsigned.
- R3: For a negative input whose magnitude is a multiple of m (for example −29 or −58), `res_o` is 0 and never m.
- R4: The input −32768 (bit pattern 0x8000) is converted with magnitude 32768, which gives `res_o` = 2 for m = 29.
- R5: `valid_o` and the matching `res_o` appear three rising edges after the edge that captures `valid_i` = 1. Inputs may arrive on every cycle, and each one yields exactly one result, in order.
- R6: While `rst` is high, and on the first cycle after it, `valid_o` is 0. `res_o` is 0 during reset.
- R7: Whenever `valid_o` is 1, `res_o` is less than m.
- R8: A cycle with `valid_i` = 0 produces no result. `valid_o` stays 0 for it whatever `data_i` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Marks `data_i` as a word to convert on this edge |
| data_i | input | 16 | Two's complement input word |
| valid_o | output | 1 | Marks `res_o` as a finished residue |
| res_o | output | 5 | Residue of the input modulo m, in 0..m−1 |

## Verification
Every one of the 65536 input patterns is sent, mostly back to back, with idle cycles carrying random data mixed in. Each result is compared with a residue computed by the remainder operator, along with the cycle in which it appears.

The corner cases each have a distinct failure signature:
- A wrong sign correction on a zero residue would put out 29 for −29 or −58.
- A sign-extended magnitude would wrongly convert −32768.
- A misplaced segment weight would corrupt large inputs only.
- A valid flag that is one stage short, or that ignores `valid_i`, would show up as a cycle mismatch or as an unexpected result.

// File: rtl/tcs_rns_pkg.sv
package tcs_rns_pkg;

    // Residue of (value * 2^(seg_w*seg_idx)) modulo 'modulus'; elaboration time only.
    function automatic int unsigned seg_weight_res(
        input int unsigned seg_idx,
        input int unsigned value,
        input int unsigned seg_w,
        input int unsigned modulus
    );
        int unsigned pw;
        pw = 1 % modulus;
        for (int unsigned i = 0; i < seg_w * seg_idx; i++) begin
            pw = (pw * 2) % modulus;
        end
        return ((value % modulus) * pw) % modulus;
    endfunction

endpackage

// File: rtl/tcs_rns_segrom.sv
module tcs_rns_segrom #(
    parameter int SEG_IDX = 0,
    parameter int SEG_W   = 5,
    parameter int MODULUS = 29,
    localparam int RES_W   = $clog2(MODULUS),
    localparam int ENTRIES = 1 << SEG_W
) (
    input  logic [SEG_W-1:0] addr_i,
    output logic [RES_W-1:0] res_o
);
    import tcs_rns_pkg::*;

    localparam logic [RES_W:0] MOD_W = (RES_W+1)'(MODULUS);

    logic [RES_W-1:0] rom [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        assign rom[e] = RES_W'(seg_weight_res(SEG_IDX, e, SEG_W, MODULUS));
    end

    assign res_o = rom[addr_i];

    always_comb begin
        AST_ROM_RANGE: assert ({1'b0, res_o} < MOD_W); // R7
    end

endmodule

// File: rtl/tcs_rns_modadd.sv
module tcs_rns_modadd #(
    parameter int MODULUS = 29,
    localparam int RES_W  = $clog2(MODULUS)
) (
    input  logic [RES_W-1:0] a_i,
    input  logic [RES_W-1:0] b_i,
    output logic [RES_W-1:0] sum_o
);
    localparam logic [RES_W:0] MOD_W = (RES_W+1)'(MODULUS);

    logic [RES_W:0]   raw;
    logic [RES_W+1:0] trial;

    always_comb begin
        raw   = {1'b0, a_i} + {1'b0, b_i};
        trial = {1'b0, raw} - {1'b0, MOD_W};
        sum_o = trial[RES_W+1] ? raw[RES_W-1:0] : trial[RES_W-1:0];
    end

    always_comb begin
        if (({1'b0, a_i} < MOD_W) && ({1'b0, b_i} < MOD_W)) begin
            AST_ADD_RANGE: assert ({1'b0, sum_o} < MOD_W); // R7
        end
    end

endmodule

// File: rtl/tcs_rns_conv.sv
module tcs_rns_conv #(
    parameter int DATA_W  = 16,
    parameter int SEG_W   = 5,
    parameter int MODULUS = 29,
    localparam int RES_W  = $clog2(MODULUS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [RES_W-1:0]  res_o
);
    localparam int NSEG   = (DATA_W + SEG_W - 1) / SEG_W;
    localparam int PAD_W  = NSEG * SEG_W;
    localparam int LEVELS = $clog2(NSEG);
    localparam int NLEAF  = 1 << LEVELS;
    localparam logic [RES_W:0] MOD_W = (RES_W+1)'(MODULUS);

    // ---------------- magnitude recovery and table lookup ----------------
    logic              in_neg;
    logic [DATA_W-1:0] mag;
    logic [PAD_W-1:0]  mag_pad;
    logic [RES_W-1:0]  seg_res [NSEG];

    always_comb begin
        in_neg  = data_i[DATA_W-1];
        mag     = in_neg ? (~data_i + DATA_W'(1)) : data_i;
        mag_pad = '0;
        mag_pad[DATA_W-1:0] = mag;
    end

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        tcs_rns_segrom #(
            .SEG_IDX (g),
            .SEG_W   (SEG_W),
            .MODULUS (MODULUS)
        ) u_rom (
            .addr_i (mag_pad[g*SEG_W +: SEG_W]),
            .res_o  (seg_res[g])
        );
    end

    // stage 1 registers
    logic             s1_vld, s1_neg;
    logic [RES_W-1:0] s1_res [NSEG];

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld <= 1'b0;
            s1_neg <= 1'b0;
            for (int i = 0; i < NSEG; i++) s1_res[i] <= '0;
        end else begin
            s1_vld <= valid_i;
            s1_neg <= in_neg;
            for (int i = 0; i < NSEG; i++) s1_res[i] <= seg_res[i];
        end
    end

    // ---------------- modular adder tree ----------------
    for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
        localparam int N = NLEAF >> lv;
        logic [RES_W-1:0] v [N];
        if (lv == 0) begin : g_leaf
            for (genvar i = 0; i < N; i++) begin : g_in
                if (i < NSEG) begin : g_used
                    assign v[i] = s1_res[i];
                end else begin : g_pad
                    assign v[i] = '0;
                end
            end
        end else begin : g_node
            for (genvar i = 0; i < N; i++) begin : g_add
                tcs_rns_modadd #(.MODULUS(MODULUS)) u_add (
                    .a_i   (g_lvl[lv-1].v[2*i]),
                    .b_i   (g_lvl[lv-1].v[2*i+1]),
                    .sum_o (v[i])
                );
            end
        end
    end

    // stage 2 registers
    logic             s2_vld, s2_neg;
    logic [RES_W-1:0] s2_sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_vld <= 1'b0;
            s2_neg <= 1'b0;
            s2_sum <= '0;
        end else begin
            s2_vld <= s1_vld;
            s2_neg <= s1_neg;
            s2_sum <= g_lvl[LEVELS].v[0];
        end
    end

    // ---------------- sign correction ----------------
    logic [RES_W:0]   neg_diff;
    logic [RES_W-1:0] fixed_res;

    always_comb begin
        neg_diff  = MOD_W - {1'b0, s2_sum};
        fixed_res = (s2_neg && (s2_sum != '0)) ? neg_diff[RES_W-1:0] : s2_sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            res_o   <= '0;
        end else begin
            valid_o <= s2_vld;
            res_o   <= fixed_res;
        end
    end

    // ---------------- assertions ----------------
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !valid_o); // R6
    AST_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ({1'b0, res_o} < MOD_W)); // R7
    AST_POS_PASS: assert property (@(posedge clk) disable iff (rst)
        (s2_vld && !s2_neg) |=> (res_o == $past(s2_sum))); // R1
    AST_NEG_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        (s2_vld && s2_neg && (s2_sum != '0)) |=> (({1'b0, res_o} + {1'b0, $past(s2_sum)}) == MOD_W)); // R2
    AST_ZERO_STAYS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (s2_vld && (s2_sum == '0)) |=> (res_o == '0)); // R3
    AST_STAGE_ONE: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> s1_vld); // R5
    AST_STAGE_OUT: assert property (@(posedge clk) disable iff (rst)
        s2_vld |=> valid_o); // R5
    AST_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
        !s2_vld |=> !valid_o); // R8

endmodule

// File: tb/tcs_rns_conv_test.sv
`timescale 1ns/100ps
module tcs_rns_conv_test;
    localparam int DW = 16;
    localparam int M  = 29;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid_i = 1'b0;
    logic [DW-1:0] data_i = '0;
    logic          valid_o;
    logic [RW-1:0] res_o;

    tcs_rns_conv #(.DATA_W(DW), .SEG_W(5), .MODULUS(M)) uut (
        .clk     (clk),
        .rst     (rst),
        .valid_i (valid_i),
        .data_i  (data_i),
        .valid_o (valid_o),
        .res_o   (res_o)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    int q_val[$];
    int q_cyc[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int ref_res(input int v);
        int r;
        r = v % M;
        if (r < 0) r += M;
        return r;
    endfunction

    function automatic string tag_of(input int v);
        if (v == -32768) return "R4";
        if (v < 0 && ((-v) % M) == 0) return "R3";
        if (v < 0) return "R2";
        return "R1";
    endfunction

    // driver: one word per call, expected item pushed to the scoreboard
    task automatic send(input logic [DW-1:0] x);
        @(negedge clk);
        data_i  = x;
        valid_i = 1'b1;
        q_val.push_back(int'($signed(x)));
        q_cyc.push_back(cyc + 3);
    endtask

    // idle cycles with junk on the data port (R8)
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            valid_i = 1'b0;
            data_i  = DW'($urandom);
        end
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (!rst && valid_o) begin
            if (q_val.size() == 0) begin
                check(1'b0, "R8", 1, 0);
            end else begin
                int v, ecyc, e;
                v    = q_val.pop_front();
                ecyc = q_cyc.pop_front();
                e    = ref_res(v);
                check(int'(res_o) == e, tag_of(v), int'(res_o), e);
                check(int'(res_o) < M, "R7", int'(res_o), M - 1);
                check(cyc == ecyc, "R5", cyc, ecyc);
            end
        end
    end

    initial begin
        #750000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0, "R6", int'(valid_o), 0);
        check(res_o == '0, "R6", int'(res_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(valid_o == 1'b0, "R6", int'(valid_o), 0);

        // directed corners: R1 R2 R3 R4
        send(16'd0); send(16'd1); send(16'd28); send(16'd29);
        send(16'hFFFF); send(-16'sd29); send(-16'sd58);
        send(16'h8000); send(16'h7FFF);
        idle(4);

        // exhaustive sweep, mostly back to back (R5), with idle gaps (R8)
        for (int i = 0; i < 65536; i++) begin
            send(i[15:0]);
            if ((i % 9) == 8) idle(1 + (i % 3));
        end

        // long idle with changing data must produce nothing (R8)
        idle(12);
        check(q_val.size() == 0, "R8", q_val.size(), 0);
        check(valid_o == 1'b0, "R8", int'(valid_o), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule